// File: doc/BRIEF.md
# Extended-Precision NaN Propagation Selector

This block settles the outcome of a two-operand floating-point operation when at least one of the operands is a NaN or an unsupported encoding. Each operand is an 80-bit extended-precision value: a sign in bit 79, a 15-bit exponent in bits 78:64, and a 64-bit significand in bits 63:0 whose bit 63 is an explicit integer bit. Each operand comes with a 2-bit class tag. The block picks the value to store and decides whether the destination register is written. It also reports whether an invalid-operation exception must be raised, and whether that exception is unmasked.

The arithmetic datapath calls the block after it classifies its operands. It also supplies a caller-chosen default NaN, which is used when the two NaNs tie, and the current invalid-operation mask bit. The decision is combinational and is registered once, so the results appear one clock after the request. The block does not update the status word and does not compute results for ordinary numbers.

Top module: `nan_prop_sel`

## Requirements
- R1: An operand is examined only when its tag is 2'b10 (special). A special operand is a NaN when bits 78:64 are all ones, bit 63 is 1 and bits 62:0 are not all zero. A special operand is unsupported when bits 78:64 are all ones and bit 63 is 0. Infinity, numbers and non-special tags are neither. `nan_hit` is 1 exactly when some operand is a NaN or is unsupported.
- R2: If either operand is unsupported, `inv_req` is 1. With `inv_mask`=1, `dest_wr` is 1 and the result is the indefinite NaN 80'hFFFF_C000_0000_0000_0000. With `inv_mask`=0, `dest_wr` is 0 and `exc_flag` is 1.
- R3: When both operands are NaNs, the operand whose bits 63:0 are larger is selected, and the sign is ignored. If bits 63:0 are equal, `dflt_nan` is selected.
- R4: When exactly one operand is a NaN, that operand is selected.
- R5: The operation is signalling when a NaN operand has bit 62 (the quiet bit) clear. `inv_req` equals this signalling condition when no operand is unsupported.
- R6: When the operation is quiet, or signalling with `inv_mask`=1, `dest_wr` is 1. The result is the selected value with bit 62 set, or the indefinite NaN if the selected value has bit 63 clear. `result` is meaningful only while `dest_wr` is 1.
- R7: When the operation is signalling with `inv_mask`=0, `dest_wr` is 0 and `exc_flag` is 1.
- R8: With no NaN and no unsupported operand, `dest_wr`, `inv_req` and `exc_flag` are 0.
- R9: `out_valid` follows `in_valid` by one clock, and the results of a request appear in that same cycle. While `out_valid` is 0, all four flags are 0.
- R10: During reset, `out_valid` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| opa | input | 80 | First operand, which is also the destination's old value |
| opb | input | 80 | Second operand |
| tag_a | input | 2 | Class tag of opa (2'b10 = special) |
| tag_b | input | 2 | Class tag of opb |
| dflt_nan | input | 80 | NaN used when two NaN significands tie |
| inv_mask | input | 1 | 1 = invalid-operation exception masked |
| out_valid | output | 1 | Result registered for the previous request |
| result | output | 80 | Value to store |
| dest_wr | output | 1 | Destination must be written |
| inv_req | output | 1 | Invalid-operation exception raised |
| exc_flag | output | 1 | Invalid raised while unmasked; the destination is kept |
| nan_hit | output | 1 | The request involved a NaN or unsupported operand |

## Verification
On every cycle, the assertions check the flag invariants. A written value is always a quiet NaN with the integer bit set. An exception never coincides with a write. A masked request never produces an exception. No flag is set without a hit or without `out_valid`, and the output valid tracks the input by one clock. Only the bench's scenarios can show which operand wins a comparison. The same holds for the tie falling back to the default NaN, including a default that is itself a pseudo-NaN, and for an infinity or a non-special tag not counting as a NaN.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

    typedef logic [1:0] tag_t;

    localparam tag_t TAG_SPECIAL = 2'b10;

    typedef struct packed {
        logic is_nan;
        logic unsup;
        logic quiet;
    } cls_t;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int FP_W = 1 + EXP_W + SIG_W
) (
    input  logic [FP_W-1:0]  op,
    input  nanp_pkg::tag_t   tag,
    output nanp_pkg::cls_t   cls
);
    logic [EXP_W-1:0] expo;
    logic [SIG_W-1:0] sig;
    logic             top_exp;
    logic             special;

    assign expo    = op[SIG_W +: EXP_W];
    assign sig     = op[SIG_W-1:0];
    assign top_exp = &expo;
    assign special = (tag == nanp_pkg::TAG_SPECIAL);

    always_comb begin
        cls.is_nan = special && top_exp && sig[SIG_W-1] && (|sig[SIG_W-2:0]);
        cls.unsup  = special && top_exp && !sig[SIG_W-1];
        cls.quiet  = sig[SIG_W-2];
    end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int FP_W = 1 + EXP_W + SIG_W
) (
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  nanp_pkg::cls_t  cls_a,
    input  nanp_pkg::cls_t  cls_b,
    input  logic [FP_W-1:0] dflt,
    output logic [FP_W-1:0] sel,
    output logic            sig_op
);
    logic [SIG_W-1:0] mag_a;
    logic [SIG_W-1:0] mag_b;

    assign mag_a = op_a[SIG_W-1:0];
    assign mag_b = op_b[SIG_W-1:0];

    always_comb begin
        sel    = op_a;
        sig_op = 1'b0;
        if (cls_a.is_nan && cls_b.is_nan) begin
            sig_op = !(cls_a.quiet && cls_b.quiet);
            if (mag_b > mag_a)
                sel = op_b;
            else if (mag_b == mag_a)
                sel = dflt;
            else
                sel = op_a;
        end else if (cls_a.is_nan) begin
            sel    = op_a;
            sig_op = !cls_a.quiet;
        end else if (cls_b.is_nan) begin
            sel    = op_b;
            sig_op = !cls_b.quiet;
        end
    end
endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int FP_W = 1 + EXP_W + SIG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [FP_W-1:0] opa,
    input  logic [FP_W-1:0] opb,
    input  logic [1:0]      tag_a,
    input  logic [1:0]      tag_b,
    input  logic [FP_W-1:0] dflt_nan,
    input  logic            inv_mask,
    output logic            out_valid,
    output logic [FP_W-1:0] result,
    output logic            dest_wr,
    output logic            inv_req,
    output logic            exc_flag,
    output logic            nan_hit
);
    localparam logic [FP_W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

    typedef struct packed {
        logic            vld;
        logic [FP_W-1:0] res;
        logic            wr;
        logic            inv;
        logic            exc;
        logic            hit;
    } state_t;

    state_t st_d, st_q;

    logic [1:0][FP_W-1:0]        ops;
    nanp_pkg::tag_t [1:0]        tags;
    nanp_pkg::cls_t [1:0]        cls;
    logic [FP_W-1:0]             sel;
    logic                        sig_op;
    logic                        any_unsup;
    logic                        any_nan;

    assign ops  = {opb, opa};
    assign tags = {tag_b, tag_a};

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        nanp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .op  (ops[gi]),
            .tag (tags[gi]),
            .cls (cls[gi])
        );
    end

    nanp_pick #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_pick (
        .op_a   (opa),
        .op_b   (opb),
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .dflt   (dflt_nan),
        .sel    (sel),
        .sig_op (sig_op)
    );

    assign any_unsup = cls[0].unsup || cls[1].unsup;
    assign any_nan   = cls[0].is_nan || cls[1].is_nan;

    always_comb begin
        st_d     = '0;
        st_d.vld = in_valid;
        st_d.res = INDEF;
        if (in_valid && (any_unsup || any_nan)) begin
            st_d.hit = 1'b1;
            if (any_unsup) begin
                st_d.inv = 1'b1;
                if (inv_mask) st_d.wr  = 1'b1;
                else          st_d.exc = 1'b1;
            end else begin
                st_d.inv = sig_op;
                if (!sig_op || inv_mask) begin
                    st_d.wr = 1'b1;
                    if (sel[SIG_W-1]) begin
                        st_d.res           = sel;
                        st_d.res[SIG_W-2]  = 1'b1;
                    end
                end else begin
                    st_d.exc = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign dest_wr   = st_q.wr;
    assign inv_req   = st_q.inv;
    assign exc_flag  = st_q.exc;
    assign nan_hit   = st_q.hit;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(dest_wr || inv_req || exc_flag || nan_hit)); // R9
    AST_NOHIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !nan_hit) |-> !(dest_wr || inv_req || exc_flag)); // R8
    AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flag |-> (!dest_wr && inv_req)); // R7
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dest_wr |-> ((&result[SIG_W +: EXP_W]) && result[SIG_W-1] && result[SIG_W-2])); // R6
    AST_MASKED_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_mask) |=> !exc_flag); // R2
endmodule

// File: tb/sim_nan_prop_sel.sv
`timescale 1ns/1ps
module sim_nan_prop_sel;
    localparam logic [79:0] IND   = 80'hFFFF_C000_0000_0000_0000;
    localparam logic [79:0] QA    = 80'h7FFF_C000_0000_0000_1234;
    localparam logic [79:0] QB    = 80'hFFFF_C000_0000_0000_5678;
    localparam logic [79:0] SA    = 80'h7FFF_8000_0000_0000_0001;
    localparam logic [79:0] PSD   = 80'h7FFF_4000_0000_0000_0000;
    localparam logic [79:0] INF   = 80'h7FFF_8000_0000_0000_0000;
    localparam logic [79:0] NUM   = 80'h3FFF_8000_0000_0000_0000;
    localparam logic [79:0] DF    = 80'h7FFF_C000_0000_0000_0ABC;
    localparam logic [79:0] DFPS  = 80'h7FFF_0000_0000_0000_0007;
    localparam logic [1:0]  SP    = 2'b10;
    localparam logic [1:0]  VL    = 2'b00;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [79:0] opa, opb, dflt_nan;
    logic [1:0]  tag_a, tag_b;
    logic        inv_mask;
    logic        out_valid, dest_wr, inv_req, exc_flag, nan_hit;
    logic [79:0] result;

    always #2 clk = ~clk;

    nan_prop_sel u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .tag_a(tag_a), .tag_b(tag_b), .dflt_nan(dflt_nan), .inv_mask(inv_mask),
        .out_valid(out_valid), .result(result), .dest_wr(dest_wr),
        .inv_req(inv_req), .exc_flag(exc_flag), .nan_hit(nan_hit)
    );

    typedef struct {
        bit          vld;
        logic [79:0] res;
        bit          wr, inv, exc, hit;
        string       req;
    } exp_t;

    exp_t  q[$];
    string cur_req = "R9";
    int    errs = 0;
    int    checks = 0;
    bit    done = 0;

    function automatic exp_t model(bit v, logic [79:0] a, logic [79:0] b,
                                   logic [1:0] ta, logic [1:0] tb,
                                   logic [79:0] d, bit m, string req);
        exp_t        e;
        bit          a_nan, b_nan, a_uns, b_uns, snan;
        logic [79:0] pick;
        e.vld = v; e.req = req; e.res = IND;
        e.wr = 0; e.inv = 0; e.exc = 0; e.hit = 0;
        snan = 0; pick = IND;
        if (!v) return e;
        a_nan = (ta == SP) && (a[78:64] == 15'h7FFF) && a[63] && (a[62:0] != 63'd0);
        b_nan = (tb == SP) && (b[78:64] == 15'h7FFF) && b[63] && (b[62:0] != 63'd0);
        a_uns = (ta == SP) && (a[78:64] == 15'h7FFF) && !a[63];
        b_uns = (tb == SP) && (b[78:64] == 15'h7FFF) && !b[63];
        if (a_uns || b_uns) begin
            e.hit = 1; e.inv = 1;
            if (m) e.wr = 1; else e.exc = 1;
            return e;
        end
        if (!a_nan && !b_nan) return e;
        e.hit = 1;
        if (a_nan && b_nan) begin
            snan = !a[62] || !b[62];
            if (a[63:0] > b[63:0])      pick = a;
            else if (b[63:0] > a[63:0]) pick = b;
            else                        pick = d;
        end else if (a_nan) begin
            snan = !a[62]; pick = a;
        end else begin
            snan = !b[62]; pick = b;
        end
        e.inv = snan;
        if (snan && !m) e.exc = 1;
        else begin
            e.wr  = 1;
            e.res = pick[63] ? (pick | (80'd1 << 62)) : IND;
        end
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst_n)
            q.push_back(model(in_valid, opa, opb, tag_a, tag_b, dflt_nan, inv_mask, cur_req));
    end

    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({out_valid, dest_wr, inv_req, exc_flag, nan_hit} !== {e.vld, e.wr, e.inv, e.exc, e.hit}) begin
                errs++;
                $display("FAIL %s flags vld/wr/inv/exc/hit actual=%b expected=%b", e.req,
                         {out_valid, dest_wr, inv_req, exc_flag, nan_hit},
                         {e.vld, e.wr, e.inv, e.exc, e.hit});
            end
            if (e.wr) begin
                checks++;
                if (result !== e.res) begin
                    errs++;
                    $display("FAIL %s result actual=%h expected=%h", e.req, result, e.res);
                end
            end
        end
    end

    task automatic drive(bit v, logic [79:0] a, logic [79:0] b, logic [1:0] ta,
                         logic [1:0] tb, logic [79:0] d, bit m, string req);
        @(negedge clk);
        in_valid = v; opa = a; opb = b; tag_a = ta; tag_b = tb;
        dflt_nan = d; inv_mask = m; cur_req = req;
    endtask

    initial begin
        rst_n = 0; in_valid = 0; opa = '0; opb = '0; tag_a = '0; tag_b = '0;
        dflt_nan = '0; inv_mask = 0;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_valid, dest_wr, inv_req, exc_flag, nan_hit} !== 5'b0) begin
            errs++;
            $display("FAIL R10 reset flags actual=%b expected=00000",
                     {out_valid, dest_wr, inv_req, exc_flag, nan_hit});
        end
        rst_n = 1;
        drive(1, QA, QB, SP, SP, DF, 1, "R3");
        drive(1, QB, QA, SP, SP, DF, 1, "R3");
        drive(1, 80'hFFFF_C000_0000_0000_0100, 80'h7FFF_C000_0000_0000_0200, SP, SP, DF, 0, "R3");
        drive(1, QA, {1'b1, QA[78:0]}, SP, SP, DF, 0, "R3");
        drive(1, QA, QA, SP, SP, DFPS, 1, "R6");
        drive(1, QA, NUM, SP, VL, DF, 0, "R4");
        drive(1, INF, QB, SP, SP, DF, 0, "R4");
        drive(1, SA, NUM, SP, VL, DF, 1, "R5");
        drive(1, SA, NUM, SP, VL, DF, 0, "R7");
        drive(1, SA, QA, SP, SP, DF, 1, "R5");
        drive(1, QA, SA, SP, SP, DF, 0, "R7");
        drive(1, PSD, QB, SP, SP, DF, 1, "R2");
        drive(1, QA, PSD, SP, SP, DF, 0, "R2");
        drive(1, QA, PSD, VL, VL, DF, 0, "R1");
        drive(1, INF, INF, SP, SP, DF, 0, "R1");
        drive(1, NUM, NUM, SP, SP, DF, 0, "R8");
        drive(0, SA, PSD, SP, SP, DF, 0, "R9");
        drive(1, SA, SA, SP, SP, DF, 1, "R5");
        drive(0, '0, '0, VL, VL, '0, 0, "R9");
        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule